// File: doc/BRIEF.md
# Message Memory Row Sequencer

This block steps a row-organised message memory through record, playback and fast message search. A one-cycle sample tick drives all timing. The block holds the current row pointer and produces a row clock that stays high for most of each row and goes low near the row's end. It stops an operation when it runs off the end of memory or finds an end-of-message marker during playback. Every such stop raises an interrupt request. It also counts the warm-up delay after a power-up request and the settling pause after a stop, both in sample ticks.

Commands arrive as a one-cycle strobe together with decoded control fields from the serial port: power, run, play/record, search and keep-going. Each row carries a small set of end-of-message marker slots. These live in an internal marker file that the surrounding logic writes. The analog sample storage is not part of this block. A command and a tick in the same cycle are resolved in favour of the command, and that tick is dropped.

Top module: `row_sequencer`

## Requirements
- R1: After reset, row_ptr is 0, rac is 1, and ovf, eom, irq, busy and ready are all 0.
- R2: A command with cmd_pwr=1 from the powered-down state starts a warm-up. ready rises after PUD_TICKS ticks. Any command other than a power-down that arrives before ready rises is ignored, so busy stays 0.
- R3: In playback, and in every record row except the first, a row lasts ROW_TICKS ticks. rac is 0 once ROW_TICKS-LOW_TICKS ticks of the row have elapsed and returns to 1 when the next row starts. rac is 1 whenever busy is 0.
- R4: The first row of a record operation lasts ROW_TICKS+LOW_TICKS ticks. rac stays 1 for its first ROW_TICKS ticks.
- R5: A start command (cmd_run=1 with cmd_keep=0) loads row_ptr from cmd_row. A value of ROWS or more loads ROWS-1. While cmd_keep is 0, each row end repeats the same row. row_ptr changes only on a tick or a command.
- R6: With the keep bit set, each row end advances row_ptr by one. A cmd_run=1, cmd_keep=1 command issued while running sets the keep bit and restarts nothing. Issued while idle, it starts from the current row.
- R7: Advancing past row ROWS-1 in record or playback sets ovf and irq, clears busy, and leaves row_ptr at ROWS-1.
- R8: In playback (cmd_play=1, cmd_cue=0), slot k of a row spans row ticks k*SLOT_TICKS to (k+1)*SLOT_TICKS-1, where SLOT_TICKS=ROW_TICKS/MARKS. If the marker for slot k of the current row is set, the tick that ends that slot sets eom and irq and clears busy, and row_ptr stays put. Record ignores markers.
- R9: In search mode (cmd_play=1, cmd_cue=1), each tick moves row_ptr one row ahead, and rac goes low for the one clock cycle after each step.
- R10: In search mode, a tick on a row that holds any marker sets eom and irq, clears busy, and moves row_ptr to the next row (it stays at ROWS-1 on the last row). A tick on the last row with no marker sets ovf and irq and clears busy.
- R11: A stop (cmd_pwr=1, cmd_run=0) while running takes effect at the next tick. busy then stays 1 for STOP_TICKS ticks in total and falls at the last of them. row_ptr does not move.
- R12: Every command clears irq, ovf and eom. A command with cmd_pwr=0 clears ready and busy at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle sample tick |
| cmd_valid | input | 1 | Command strobe |
| cmd_pwr | input | 1 | 1 = stay powered, 0 = stop and power down |
| cmd_run | input | 1 | 1 = start an operation, 0 = stop |
| cmd_play | input | 1 | 1 = playback, 0 = record |
| cmd_cue | input | 1 | Search mode (playback only) |
| cmd_keep | input | 1 | Keep going: ignore cmd_row and advance at row ends |
| cmd_row | input | ROW_W | Start row |
| mark_we | input | 1 | Marker write strobe |
| mark_row | input | ROW_W | Marker row to write |
| mark_slot | input | SLOT_W | Marker slot to write |
| mark_val | input | 1 | Marker value |
| row_ptr | output | ROW_W | Current row |
| rac | output | 1 | Row clock |
| ovf | output | 1 | End of memory reached |
| eom | output | 1 | End-of-message marker found |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Operation or stop pause in progress |
| ready | output | 1 | Powered and warm-up complete |

## Verification
The bench builds the block with 6 rows of 16 ticks, a row-clock low phase of 4 ticks, 4 marker slots per row, a 3-tick warm-up and a 5-tick pause. Because rows are this short, the bench can walk a whole record pass from row 0 into overflow. It can also exercise the stretched first record row, a repeated row, a stop part-way through a row, and search mode over several rows in a few hundred cycles. With few rows, the last-row corner cases of overflow and of a marker found in search mode come within reach of short directed tests.

// File: rtl/row_seq_pkg.sv
// Shared types for the row sequencer.
package row_seq_pkg;
    typedef enum logic [2:0] {
        RS_OFF,
        RS_WARM,
        RS_IDLE,
        RS_RUN,
        RS_PAUSE
    } rs_state_t;
endpackage

// File: rtl/rs_marker_file.sv
// End-of-message marker store: MARKS flag bits per row.
// Assumes one write per cycle; writes to rows at or beyond ROWS are dropped.
module rs_marker_file #(
    parameter int ROWS  = 600,
    parameter int MARKS = 8,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int SLOT_W = $clog2(MARKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_val,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [MARKS-1:0]  rd_marks
);
    localparam logic [ROW_W:0] ROWS_X = ROWS;

    logic [MARKS-1:0] mem [ROWS];

    // Clear on reset, single-bit update on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= '0;
        end else if (we && ({1'b0, wr_row} < ROWS_X)) begin
            mem[wr_row][wr_slot] <= wr_val;
        end
    end

    // Asynchronous read of the current row's markers.
    always_comb begin
        rd_marks = '0;
        if ({1'b0, rd_row} < ROWS_X) rd_marks = mem[rd_row];
    end
endmodule

// File: rtl/rs_row_clock.sv
// Row timing decode: row clock level, row-end and slot-end flags, slot index.
// Assumes cnt counts ticks elapsed in the current row; ROW_TICKS divisible by MARKS.
module rs_row_clock #(
    parameter int ROW_TICKS = 1600,
    parameter int LOW_TICKS = 200,
    parameter int MARKS     = 8,
    parameter int CNT_W     = 11,
    localparam int SLOT_W     = $clog2(MARKS),
    localparam int SLOT_TICKS = ROW_TICKS / MARKS
) (
    input  logic              running,
    input  logic              cue,
    input  logic              first,
    input  logic              cue_pulse,
    input  logic [CNT_W-1:0]  cnt,
    output logic              rac,
    output logic              row_last,
    output logic              slot_last,
    output logic [SLOT_W-1:0] slot_idx
);
    localparam logic [CNT_W-1:0] LAST_N   = CNT_W'(ROW_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_F   = CNT_W'(ROW_TICKS + LOW_TICKS - 1);
    localparam logic [CNT_W-1:0] LOW_N    = CNT_W'(ROW_TICKS - LOW_TICKS);
    localparam logic [CNT_W-1:0] LOW_F    = CNT_W'(ROW_TICKS);
    localparam logic [CNT_W-1:0] SLOT_D   = CNT_W'(SLOT_TICKS);
    localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(SLOT_TICKS - 1);

    // Row length and low phase depend on whether this is a stretched first row.
    always_comb begin
        row_last  = (cnt == (first ? LAST_F : LAST_N));
        slot_last = ((cnt % SLOT_D) == SLOT_END);
        slot_idx  = SLOT_W'(cnt / SLOT_D);
        if (!running)  rac = 1'b1;
        else if (cue)  rac = !cue_pulse;
        else           rac = !(cnt >= (first ? LOW_F : LOW_N));
    end
endmodule

// File: rtl/row_sequencer.sv
// Row sequencer: walks the message memory in record, playback and search modes.
// Assumes tick is a one-cycle pulse; a command in the same cycle as a tick wins.
module row_sequencer #(
    parameter int ROWS       = 600,
    parameter int ROW_TICKS  = 1600,
    parameter int LOW_TICKS  = 200,
    parameter int MARKS      = 8,
    parameter int PUD_TICKS  = 200,
    parameter int STOP_TICKS = 400,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int SLOT_W = $clog2(MARKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic              cmd_pwr,
    input  logic              cmd_run,
    input  logic              cmd_play,
    input  logic              cmd_cue,
    input  logic              cmd_keep,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic              mark_we,
    input  logic [ROW_W-1:0]  mark_row,
    input  logic [SLOT_W-1:0] mark_slot,
    input  logic              mark_val,
    output logic [ROW_W-1:0]  row_ptr,
    output logic              rac,
    output logic              ovf,
    output logic              eom,
    output logic              irq,
    output logic              busy,
    output logic              ready
);
    import row_seq_pkg::*;

    localparam int MAXA  = (ROW_TICKS + LOW_TICKS > PUD_TICKS) ? ROW_TICKS + LOW_TICKS : PUD_TICKS;
    localparam int MAXC  = (MAXA > STOP_TICKS) ? MAXA : STOP_TICKS;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] PUD_LAST  = CNT_W'(PUD_TICKS - 1);
    localparam logic [CNT_W-1:0] STOP_LAST = CNT_W'(STOP_TICKS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(ROWS - 1);
    localparam logic [ROW_W:0]   ROWS_X    = ROWS;

    rs_state_t         state_q;
    logic [ROW_W-1:0]  row_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              first_q, rec_q, cue_q, keep_q, stop_q;
    logic              ovf_q, eom_q, irq_q, pulse_q;
    logic [MARKS-1:0]  marks;
    logic              row_last, slot_last;
    logic [SLOT_W-1:0] slot_idx;
    logic              running;

    assign running = (state_q == RS_RUN);

    rs_marker_file #(.ROWS(ROWS), .MARKS(MARKS)) u_marks (
        .clk(clk), .rst_n(rst_n), .we(mark_we), .wr_row(mark_row),
        .wr_slot(mark_slot), .wr_val(mark_val), .rd_row(row_q), .rd_marks(marks)
    );

    rs_row_clock #(.ROW_TICKS(ROW_TICKS), .LOW_TICKS(LOW_TICKS), .MARKS(MARKS), .CNT_W(CNT_W)) u_clock (
        .running(running), .cue(cue_q), .first(first_q), .cue_pulse(pulse_q), .cnt(cnt_q),
        .rac(rac), .row_last(row_last), .slot_last(slot_last), .slot_idx(slot_idx)
    );

    // Command decode, delay timing and row stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_OFF;  row_q  <= '0;   cnt_q   <= '0;
            first_q <= 1'b0;    rec_q  <= 1'b0; cue_q   <= 1'b0;
            keep_q  <= 1'b0;    stop_q <= 1'b0; ovf_q   <= 1'b0;
            eom_q   <= 1'b0;    irq_q  <= 1'b0; pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (cmd_valid) begin
                irq_q <= 1'b0;
                ovf_q <= 1'b0;
                eom_q <= 1'b0;
                if (!cmd_pwr) begin
                    state_q <= RS_OFF;
                    stop_q  <= 1'b0;
                end else begin
                    case (state_q)
                        RS_OFF: begin
                            state_q <= RS_WARM;
                            cnt_q   <= '0;
                        end
                        RS_WARM: ;
                        default: begin
                            if (cmd_run && running && cmd_keep) begin
                                keep_q <= 1'b1;
                            end else if (cmd_run) begin
                                state_q <= RS_RUN;
                                if (!cmd_keep)
                                    row_q <= ({1'b0, cmd_row} >= ROWS_X) ? LAST_ROW : cmd_row;
                                keep_q  <= cmd_keep;
                                rec_q   <= !cmd_play;
                                cue_q   <= cmd_play && cmd_cue;
                                first_q <= !cmd_play;
                                cnt_q   <= '0;
                                stop_q  <= 1'b0;
                            end else if (running) begin
                                stop_q <= 1'b1;
                            end
                        end
                    endcase
                end
            end else if (tick) begin
                case (state_q)
                    RS_WARM: begin
                        if (cnt_q == PUD_LAST) state_q <= RS_IDLE;
                        else                   cnt_q   <= cnt_q + 1'b1;
                    end
                    RS_PAUSE: begin
                        if (cnt_q == STOP_LAST) state_q <= RS_IDLE;
                        else                    cnt_q   <= cnt_q + 1'b1;
                    end
                    RS_RUN: begin
                        if (stop_q) begin
                            state_q <= RS_PAUSE;
                            cnt_q   <= '0;
                            stop_q  <= 1'b0;
                        end else if (cue_q) begin
                            if (|marks) begin
                                eom_q   <= 1'b1;
                                irq_q   <= 1'b1;
                                state_q <= RS_IDLE;
                                if (row_q != LAST_ROW) row_q <= row_q + 1'b1;
                            end else if (row_q == LAST_ROW) begin
                                ovf_q   <= 1'b1;
                                irq_q   <= 1'b1;
                                state_q <= RS_IDLE;
                            end else begin
                                row_q   <= row_q + 1'b1;
                                pulse_q <= 1'b1;
                            end
                        end else if (!rec_q && slot_last && marks[slot_idx]) begin
                            eom_q   <= 1'b1;
                            irq_q   <= 1'b1;
                            state_q <= RS_IDLE;
                        end else if (row_last) begin
                            cnt_q   <= '0;
                            first_q <= 1'b0;
                            if (keep_q) begin
                                if (row_q == LAST_ROW) begin
                                    ovf_q   <= 1'b1;
                                    irq_q   <= 1'b1;
                                    state_q <= RS_IDLE;
                                end else begin
                                    row_q <= row_q + 1'b1;
                                end
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output mapping.
    always_comb begin
        row_ptr = row_q;
        ovf     = ovf_q;
        eom     = eom_q;
        irq     = irq_q;
        busy    = (state_q == RS_RUN) || (state_q == RS_PAUSE);
        ready   = (state_q == RS_IDLE) || busy;
    end
endmodule

// File: rtl/row_sequencer_chk.sv
// Property checker for the row sequencer, attached through bind.
// Assumes only the top-level ports are visible.
module row_sequencer_chk #(
    parameter int ROWS = 600,
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cmd_valid,
    input logic [ROW_W-1:0] row_ptr,
    input logic             rac,
    input logic             ovf,
    input logic             eom,
    input logic             irq,
    input logic             busy,
    input logic             ready
);
    localparam logic [ROW_W:0] ROWS_X = ROWS;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    assert_rac_idle_R3: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> rac);
    assert_busy_ready_R2: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> !busy);
    assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n) {1'b0, row_ptr} < ROWS_X);
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cmd_valid) |=> $stable(row_ptr));
    assert_ovf_last_R7: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf) |-> (row_ptr == LAST_ROW));
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (ovf || eom));
    assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq) |-> $past(cmd_valid));
endmodule

bind row_sequencer row_sequencer_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .row_ptr(row_ptr),
    .rac(rac), .ovf(ovf), .eom(eom), .irq(irq), .busy(busy), .ready(ready)
);

// File: tb/row_sequencer_tb.sv
// Directed bench for the row sequencer with short rows.
module row_sequencer_tb;
    localparam int ROWS = 6, ROW_TICKS = 16, LOW_TICKS = 4, MARKS = 4, PUD = 3, STOP = 5;
    localparam int ROW_W = $clog2(ROWS), SLOT_W = $clog2(MARKS);

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cmd_valid = 1'b0;
    logic cmd_pwr = 1'b0, cmd_run = 1'b0, cmd_play = 1'b0, cmd_cue = 1'b0, cmd_keep = 1'b0;
    logic [ROW_W-1:0] cmd_row = '0, mark_row = '0;
    logic [SLOT_W-1:0] mark_slot = '0;
    logic mark_we = 1'b0, mark_val = 1'b0;
    logic [ROW_W-1:0] row_ptr;
    logic rac, ovf, eom, irq, busy, ready;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    row_sequencer #(.ROWS(ROWS), .ROW_TICKS(ROW_TICKS), .LOW_TICKS(LOW_TICKS), .MARKS(MARKS),
                    .PUD_TICKS(PUD), .STOP_TICKS(STOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_pwr(cmd_pwr),
        .cmd_run(cmd_run), .cmd_play(cmd_play), .cmd_cue(cmd_cue), .cmd_keep(cmd_keep),
        .cmd_row(cmd_row), .mark_we(mark_we), .mark_row(mark_row), .mark_slot(mark_slot),
        .mark_val(mark_val), .row_ptr(row_ptr), .rac(rac), .ovf(ovf), .eom(eom), .irq(irq),
        .busy(busy), .ready(ready)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic cmd(input logic pwr, run, play, cue, keep, input int row);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_pwr = pwr; cmd_run = run; cmd_play = play;
        cmd_cue = cue; cmd_keep = keep; cmd_row = ROW_W'(row);
        @(negedge clk) cmd_valid = 1'b0;
    endtask

    task automatic mark(input int row, input int slot, input logic val);
        @(negedge clk);
        mark_we = 1'b1; mark_row = ROW_W'(row); mark_slot = SLOT_W'(slot); mark_val = val;
        @(negedge clk) mark_we = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 row_ptr", row_ptr, 0); check("R1 rac", rac, 1);
        check("R1 flags", {ovf, eom, irq}, 0); check("R1 busy/ready", {busy, ready}, 0);
    endtask

    task automatic t_power;
        cmd(1, 0, 0, 0, 0, 0);
        check("R2 ready low in warm-up", ready, 0);
        cmd(1, 1, 1, 0, 0, 2);
        check("R2 start ignored in warm-up", busy, 0);
        ticks(PUD - 1); check("R2 ready before delay", ready, 0);
        ticks(1);       check("R2 ready after delay", ready, 1);
        check("R2 still idle", busy, 0);
    endtask

    task automatic t_play_rows;
        cmd(1, 1, 1, 0, 0, 2);
        check("R5 start loads row", row_ptr, 2); check("R3 busy", busy, 1);
        ticks(ROW_TICKS - LOW_TICKS - 1); check("R3 rac high", rac, 1);
        ticks(1); check("R3 rac low phase", rac, 0);
        ticks(LOW_TICKS - 1); check("R3 rac still low", rac, 0);
        ticks(1); check("R3 rac high at new row", rac, 1);
        check("R5 row repeats", row_ptr, 2);
        cmd(1, 1, 1, 0, 1, 0);
        check("R6 continue keeps row", row_ptr, 2);
        ticks(ROW_TICKS); check("R6 row advances", row_ptr, 3);
        cmd(1, 0, 0, 0, 0, 0);
        check("R11 stop waits for tick", busy, 1);
        ticks(1); check("R11 pause rac", rac, 1);
        ticks(STOP - 1); check("R11 busy in pause", busy, 1);
        ticks(1); check("R11 idle after pause", busy, 0);
        check("R11 row frozen", row_ptr, 3);
    endtask

    task automatic t_record;
        mark(1, 0, 1'b1);
        cmd(1, 1, 0, 0, 0, 0);
        cmd(1, 1, 0, 0, 1, 0);
        ticks(ROW_TICKS - 1); check("R4 first row rac high", rac, 1);
        ticks(1); check("R4 first row rac low", rac, 0);
        check("R4 still row 0", row_ptr, 0);
        ticks(LOW_TICKS); check("R4 row 1 reached", row_ptr, 1);
        ticks(ROW_TICKS - LOW_TICKS); check("R8 record ignores marker", busy, 1);
        check("R3 second record row normal", rac, 0);
        ticks(LOW_TICKS + 3 * ROW_TICKS); check("R7 last row", row_ptr, ROWS - 1);
        check("R7 no ovf yet", ovf, 0);
        ticks(ROW_TICKS);
        check("R7 ovf", ovf, 1); check("R7 irq", irq, 1);
        check("R7 busy", busy, 0); check("R7 row held", row_ptr, ROWS - 1);
        cmd(1, 0, 0, 0, 0, 0);
        check("R12 irq cleared", irq, 0); check("R12 ovf cleared", ovf, 0);
    endtask

    task automatic t_eom;
        cmd(1, 1, 1, 0, 1, 5);
        cmd(1, 1, 1, 0, 0, 1);
        ticks(ROW_TICKS / MARKS - 1); check("R8 before slot end", eom, 0);
        ticks(1);
        check("R8 eom", eom, 1); check("R8 irq", irq, 1);
        check("R8 stopped", busy, 0); check("R8 row kept", row_ptr, 1);
    endtask

    task automatic t_cue;
        mark(4, MARKS - 1, 1'b1);
        cmd(1, 1, 1, 1, 0, 2);
        check("R12 eom cleared", eom, 0);
        ticks(1); check("R9 one row per tick", row_ptr, 3);
        check("R9 rac pulse low", rac, 0);
        @(negedge clk); check("R9 rac back high", rac, 1);
        ticks(1); check("R9 second step", row_ptr, 4);
        ticks(1);
        check("R10 eom", eom, 1); check("R10 next message", row_ptr, 5);
        check("R10 stopped", busy, 0);
        mark(4, MARKS - 1, 1'b0);
        cmd(1, 1, 1, 1, 0, 2);
        ticks(3); check("R10 at last row", row_ptr, 5);
        ticks(1);
        check("R10 ovf", ovf, 1); check("R10 busy", busy, 0);
    endtask

    task automatic t_pwrdn;
        cmd(1, 1, 1, 0, 0, 7);
        check("R5 clamp row", row_ptr, ROWS - 1);
        cmd(0, 0, 0, 0, 0, 0);
        check("R12 busy cleared", busy, 0); check("R12 ready cleared", ready, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_power;
        t_play_rows;
        t_record;
        t_eom;
        t_cue;
        t_pwrdn;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule